// File: doc/BRIEF.md
# Peripheral Interrupt Mask and Status Bank

This block sits at the edge of a peripheral. It turns the peripheral's event bits into one interrupt request for the system interrupt controller. Hardware logic in the peripheral raises status bits with one-cycle event pulses and lowers them with clear strobes. A mask register decides which status bits may raise the request. The request output is the registered OR, over all bit positions, of each status bit ANDed with its mask bit.

Software changes the mask through two write-only command words. Writing ones to the arm word sets the matching mask bits. Writing ones to the disarm word clears them. Zero bits in either word leave their mask bits alone. A single bus write can therefore arm or disarm any group of sources at once, and no read-modify-write sequence is needed. The mask and the status can each be read back from their own read-only word. The bus is a plain single-cycle register port, and read data is registered one cycle after the address.

Top module: `irq_gate_regs`

## Requirements
- R1: After synchronous reset the mask, the status bits, `irq` and `bus_rdata` are all zero.
- R2: A bus write to word address 2 (arm) sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A bus write to word address 3 (disarm) clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: Word address 0 reads the status bits and word address 1 reads the mask, both in the low NBITS bits of `bus_rdata`. `bus_rdata` shows the register selected by `bus_addr` at the previous rising edge.
- R5: Bus writes to word addresses 0 and 1, and to any address above 3, change neither the mask nor the status.
- R6: Data bits at positions NBITS and above always read as 0, and writing them has no effect. Reads of the two command words and of any address above 3 return 0.
- R7: A 1 on bit i of `ev_set` for one cycle sets status bit i. The bit then stays set until a 1 on bit i of `ev_clr`.
- R8: When bit i of `ev_set` and bit i of `ev_clr` are both 1 in the same cycle, status bit i ends up set.
- R9: `irq` equals the OR over all bits of (mask AND status) as both stood one cycle earlier. A change to the mask or to the status therefore reaches `irq` on the edge after the edge that made the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_set | input | NBITS | Per-bit hardware event pulses that set status bits |
| ev_clr | input | NBITS | Per-bit hardware strobes that clear status bits |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | AW | Word address for reads and writes |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Registered interrupt-source request |

## Verification
The hardest case to reach from the ports is a mask write that lands on a bit that is already set or already cleared. This matters most when the write pattern has ones above NBITS. The mask bench handles it with a full sweep over a small four-bit configuration. For every pair of patterns it clears the mask, arms one pattern and then a second, disarms the second, and reads the mask back after each step. Upper data bits are always driven to 1 in these writes. The output timing of `irq` is caught by sampling it once right after an arming write, when it must still show the old mask, and again one cycle later, for every mask against every status pattern. A set pulse and a clear strobe on the same bit in one cycle are driven with all sixteen by sixteen combinations.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  // Word addresses of the register port
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_MASK   = 1;
  localparam int unsigned ADDR_ARM    = 2;
  localparam int unsigned ADDR_DISARM = 3;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_ZERO   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] arm_bits,
  input  logic [NBITS-1:0] disarm_bits,
  output logic [NBITS-1:0] mask_q
);
  // disarm applied after arm: disarm takes priority on a shared bit
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q | arm_bits) & ~disarm_bits;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] ev_set,
  input  logic [NBITS-1:0] ev_clr,
  output logic [NBITS-1:0] stat_q
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            stat_q[i] <= 1'b0;
      else if (ev_set[i]) stat_q[i] <= 1'b1;   // set beats clear
      else if (ev_clr[i]) stat_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int NBITS = 8,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NBITS-1:0] mask_q,
  input  logic [NBITS-1:0] stat_q,
  output logic [DW-1:0]    rdata
);
  import irq_gate_pkg::*;

  rd_sel_e sel;

  always_comb begin
    if (rd_addr == AW'(ADDR_STATUS))    sel = SEL_STATUS;
    else if (rd_addr == AW'(ADDR_MASK)) sel = SEL_MASK;
    else                                sel = SEL_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (sel)
        SEL_STATUS: rdata <= DW'(stat_q);
        SEL_MASK:   rdata <= DW'(mask_q);
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_gate_regs.sv
module irq_gate_regs #(
  parameter int NBITS = 8,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] ev_set,
  input  logic [NBITS-1:0] ev_clr,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  import irq_gate_pkg::*;

  localparam logic [DW-1:0] KEEP = {DW{1'b1}} >> (DW - NBITS);

  logic [NBITS-1:0] wbits;
  logic [NBITS-1:0] arm_bits;
  logic [NBITS-1:0] disarm_bits;
  logic [NBITS-1:0] mask_q;
  logic [NBITS-1:0] stat_q;

  // data bits above NBITS are discarded here
  assign wbits       = NBITS'(bus_wdata & KEEP);
  assign arm_bits    = (bus_wr && bus_addr == AW'(ADDR_ARM))    ? wbits : '0;
  assign disarm_bits = (bus_wr && bus_addr == AW'(ADDR_DISARM)) ? wbits : '0;

  irq_mask_bank #(.NBITS(NBITS)) u_mask (
    .clk(clk), .rst(rst),
    .arm_bits(arm_bits), .disarm_bits(disarm_bits),
    .mask_q(mask_q)
  );

  irq_status_bank #(.NBITS(NBITS)) u_stat (
    .clk(clk), .rst(rst),
    .ev_set(ev_set), .ev_clr(ev_clr),
    .stat_q(stat_q)
  );

  irq_read_port #(.NBITS(NBITS), .DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst),
    .rd_addr(bus_addr), .mask_q(mask_q), .stat_q(stat_q),
    .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(mask_q & stat_q);
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int NBITS = 8,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NBITS-1:0] ev_set,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NBITS-1:0] mask_q,
  input logic [NBITS-1:0] stat_q,
  input logic             irq
);
  logic cmd_wr;
  assign cmd_wr = bus_wr && (bus_addr == AW'(2) || bus_addr == AW'(3));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && mask_q == '0 && stat_q == '0));

  assert_arm_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(2)) |=>
      ((mask_q & $past(bus_wdata[NBITS-1:0])) == $past(bus_wdata[NBITS-1:0])) &&
      ((mask_q & ~$past(bus_wdata[NBITS-1:0])) == ($past(mask_q) & ~$past(bus_wdata[NBITS-1:0]))));

  assert_disarm_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(3)) |=>
      mask_q == ($past(mask_q) & ~$past(bus_wdata[NBITS-1:0])));

  assert_other_writes_inert_R5: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> $stable(mask_q));

  assert_event_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_set != '0) |=> ((stat_q & $past(ev_set)) == $past(ev_set)));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (|($past(mask_q) & $past(stat_q))));

  always @(negedge clk) begin
    if (!rst) assert_high_bits_zero_R6: assert ((bus_rdata >> NBITS) == '0);
  end
endmodule

bind irq_gate_regs irq_gate_chk #(.NBITS(NBITS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ev_set(ev_set), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .mask_q(mask_q), .stat_q(stat_q), .irq(irq)
);

// File: tb/sim_irq_gate_regs.sv
`timescale 1ns/1ps
module sim_irq_gate_regs;
  localparam int NBITS = 4;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam logic [NBITS-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NBITS-1:0] ev_set = '0, ev_clr = '0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [NBITS-1:0] exp_mask = '0, exp_stat = '0;
  logic [DW-1:0] rv;

  always #2 clk = ~clk;

  irq_gate_regs #(.NBITS(NBITS), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .ev_set(ev_set), .ev_clr(ev_clr),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(int a, logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    if (a == 2) exp_mask = exp_mask | d[NBITS-1:0];
    if (a == 3) exp_mask = exp_mask & ~d[NBITS-1:0];
  endtask

  task automatic rd(int a, output logic [DW-1:0] v);
    bus_addr = AW'(a);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pulse(logic [NBITS-1:0] s, logic [NBITS-1:0] c);
    ev_set = s; ev_clr = c;
    @(negedge clk);
    ev_set = '0; ev_clr = '0;
    exp_stat = (exp_stat & ~c) | s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(0, rv); chk("R1 status", rv, 0);
    rd(1, rv); chk("R1 mask", rv, 0);

    // R2 R3 R6: exhaustive mask sweep, upper data bits driven high
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(3, '1);
        wr(2, DW'(8'hF0 | a));
        wr(2, DW'(8'hF0 | b));
        rd(1, rv); chk("R2 arm keeps and sets", rv, DW'(a | b));
        wr(3, DW'(8'hF0 | b));
        rd(1, rv); chk("R3 disarm clears", rv, DW'(a & ~b & 4'hF));
      end
    end

    // R7 R9: each status pattern against each mask
    for (int p = 0; p < 16; p++) begin
      pulse('0, ALL);
      pulse(NBITS'(p), '0);
      repeat (2) @(negedge clk);
      rd(0, rv); chk("R7 status held", rv, DW'(p));
      for (int m = 0; m < 16; m++) begin
        wr(3, '1);
        @(negedge clk);
        wr(2, DW'(m));
        chk("R9 irq not yet updated", irq, 0);
        rd(0, rv);
        chk("R9 irq after mask write", irq, 32'(|(NBITS'(m) & NBITS'(p))));
      end
    end

    // R9 status path timing with full mask
    wr(2, '1);
    pulse('0, ALL);
    @(negedge clk);
    pulse(4'b0100, '0);
    chk("R9 irq lags status", irq, 0);
    @(negedge clk);
    chk("R9 irq after status", irq, 1);
    pulse('0, 4'b0100);
    @(negedge clk);
    chk("R9 irq drops after clear", irq, 0);

    // R8 same-cycle set and clear
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        pulse(NBITS'(c), '0);
        pulse(NBITS'(s), NBITS'(c));
        rd(0, rv); chk("R8 set wins", rv, DW'(exp_stat));
      end
    end

    // R5 writes to read-only and unmapped words
    pulse('0, ALL); pulse(4'b1010, '0);
    wr(3, '1); wr(2, DW'(4'b0110));
    wr(0, '1);
    rd(0, rv); chk("R5 status write ignored", rv, DW'(4'b1010));
    wr(0, '0);
    rd(0, rv); chk("R5 status zero write ignored", rv, DW'(4'b1010));
    wr(1, '1);
    rd(1, rv); chk("R5 mask write ignored", rv, DW'(4'b0110));
    for (int a = 4; a < 8; a++) begin
      wr(a, '1);
      rd(1, rv); chk("R5 unmapped write mask", rv, DW'(4'b0110));
      rd(0, rv); chk("R5 unmapped write status", rv, DW'(4'b1010));
    end

    // R6 reads of command and unmapped words
    for (int a = 2; a < 8; a++) begin
      rd(a, rv); chk("R6 read zero", rv, 0);
    end
    // R4 read latency: value tracks address of previous edge
    bus_addr = AW'(1);
    @(negedge clk);
    bus_addr = AW'(0);
    chk("R4 mask visible", bus_rdata, DW'(4'b0110));
    @(negedge clk);
    chk("R4 status visible", bus_rdata, DW'(4'b1010));
    chk("R9 final irq", irq, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule